// File: doc/BRIEF.md
# Debug-Aware Low-Power Clock Controller

This block sequences a small processor system through its low-power states and controls the clocking and supply around them. When the CPU executes a wait-for-interrupt or wait-for-event instruction, a mode-select input picks sleep, stop or standby. The block drives a gate enable for the free-running core clock and one for the bus clock. It also drives a clock-source select (main system clock or internal RC oscillator), a regulator enable and an internal system-reset request.

A three-bit debug configuration register changes how each low-power state behaves, so that a debugger can stay attached while the core sleeps. In sleep, the sleep override keeps the bus clock running from the system clock. In stop, the stop override keeps both core clocks running from the RC oscillator. In standby, the standby override also keeps the regulators on. Both a debugger port and the software bus can write the register. The system reset does not clear it, so a debugger can set it up before releasing reset.

Any change of clock source happens only while both clock gates are closed, with one closed cycle on each side of the change. Waking from standby always ends in a fixed-length internal reset pulse, so execution restarts exactly as it does after reset.

Top module: `lp_clk_ctrl`

## Requirements
- R1: The configuration register holds sleep override at bit 0, stop override at bit 1 and standby override at bit 2; all higher read-data bits read zero. Either write port updates it on the clock edge that samples its write strobe, and when both write in the same cycle the debugger port value is stored.
- R2: Only the power-on reset (rst_ni low) clears the register to zero. While the system reset (sys_rst_ni low) is held, the register keeps its value and still accepts writes.
- R3: Mode select 0 is sleep, 1 is stop, and 2 or 3 is standby. A low-power state is entered only on a cycle where wfi_i or wfe_i is high, and RUN is left on no other input. In RUN both clock enables are 1, the source select is 0 (main clock), the regulator enable is 1 and the reset request is 0.
- R4: In sleep, the core clock enable stays 1, the source stays main, and the bus clock enable equals the sleep override bit.
- R5: In stop without override, both clock enables are 0 on the main source. With the override set, both clocks stay enabled on source 1 (RC oscillator). The regulator stays on in both cases.
- R6: In standby without override, the clock enables and the regulator enable are all 0. With the override set, the regulator stays on and both clocks run from the RC oscillator.
- R7: In sleep or stop, a high wake_i returns the block to RUN on the edge that samples it. When no source change is needed, the RUN clock enables are present in the cycle after that edge.
- R8: A source change is glitch-free. When a state change needs a new source, both enables are 0 in the cycle after the state edge. The source select changes on the next edge, both enables are still 0 for one more cycle, and only then do they take their new values.
- R9: A wake_i in standby, with or without override, raises sys_rst_req_o in the cycle after the sampling edge. The request is held for exactly 4 cycles, and then the block is in RUN.
- R10: A low sys_rst_ni returns sleep, stop and standby to RUN on the next edge, but does not shorten an internal reset pulse already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_ni | input | 1 | System reset, active low, synchronous |
| wfi_i | input | 1 | CPU executes wait-for-interrupt |
| wfe_i | input | 1 | CPU executes wait-for-event |
| mode_i | input | 2 | Requested low-power mode |
| wake_i | input | 1 | Interrupt or event wake-up |
| dbg_we_i | input | 1 | Debugger register write strobe |
| dbg_wdata_i | input | DW | Debugger write data |
| sw_we_i | input | 1 | Software register write strobe |
| sw_wdata_i | input | DW | Software write data |
| cfg_rdata_o | output | DW | Register read data |
| fclk_en_o | output | 1 | Free-running core clock gate enable |
| hclk_en_o | output | 1 | Bus clock gate enable |
| clk_sel_o | output | 1 | Clock source: 0 main, 1 RC oscillator |
| reg_en_o | output | 1 | Regulator enable |
| sys_rst_req_o | output | 1 | Internal system reset request |

## Verification
The state register updates on the edge that samples wfi_i, wfe_i or wake_i. The enables, regulator and reset outputs follow combinationally, so they are due in the next cycle. With a source change, the select is due one cycle later and the enables two cycles later. A register write shows on the read port one cycle after its strobe. The bench drives every input just after a falling edge and samples just after the next falling edge, stepping one whole cycle per expected register stage. The standby exit pulse is counted over eight sampled cycles instead of being checked only at its ends.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int CFG_W = 3;

  localparam logic [1:0] MODE_SLEEP = 2'd0;
  localparam logic [1:0] MODE_STOP  = 2'd1;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_STOP,
    ST_STBY,
    ST_RSTX
  } lp_state_e;

  // bit0 sleep, bit1 stop, bit2 standby
  typedef struct packed {
    logic stby_dbg;
    logic stop_dbg;
    logic sleep_dbg;
  } lp_cfg_t;

  typedef struct packed {
    logic fclk_en;
    logic hclk_en;
    logic sel_rc;
    logic reg_en;
  } lp_clk_req_t;
endpackage

// File: rtl/lp_dbg_cfg.sv
module lp_dbg_cfg
  import lp_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dbg_we_i,
  input  logic [DW-1:0] dbg_wdata_i,
  input  logic          sw_we_i,
  input  logic [DW-1:0] sw_wdata_i,
  output lp_cfg_t       cfg_o,
  output logic [DW-1:0] rdata_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             unused_hi;

  assign unused_hi = ^{dbg_wdata_i[DW-1:CFG_W], sw_wdata_i[DW-1:CFG_W]};

  // only power-on reset clears; system reset is not connected here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (dbg_we_i) cfg_q <= dbg_wdata_i[CFG_W-1:0];
    else if (sw_we_i)  cfg_q <= sw_wdata_i[CFG_W-1:0];
  end

  assign cfg_o   = lp_cfg_t'(cfg_q);
  assign rdata_o = {{(DW-CFG_W){1'b0}}, cfg_q};

  a_r1_dbg_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_we_i |=> cfg_q == $past(dbg_wdata_i[CFG_W-1:0]));

  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dbg_we_i && !sw_we_i) |=> $stable(cfg_q));
endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_pkg::*;
#(
  parameter int RST_CYC = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sys_rst_ni,
  input  logic        wfi_i,
  input  logic        wfe_i,
  input  logic [1:0]  mode_i,
  input  logic        wake_i,
  input  lp_cfg_t     cfg_i,
  output lp_clk_req_t req_o,
  output logic        sys_rst_req_o
);
  localparam int CW = $clog2(RST_CYC) + 1;

  lp_state_e state_q, state_d;
  logic [CW-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN: begin
        if (wfi_i || wfe_i) begin
          if (mode_i == MODE_SLEEP)     state_d = ST_SLEEP;
          else if (mode_i == MODE_STOP) state_d = ST_STOP;
          else                          state_d = ST_STBY;
        end
      end
      ST_SLEEP, ST_STOP: if (wake_i) state_d = ST_RUN;
      ST_STBY:           if (wake_i) state_d = ST_RSTX;
      ST_RSTX:           if (cnt_q == CW'(RST_CYC - 1)) state_d = ST_RUN;
      default:           state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
    end else begin
      // system reset aborts low-power states but not the exit pulse
      if (!sys_rst_ni && state_q != ST_RSTX) state_q <= ST_RUN;
      else                                   state_q <= state_d;
      cnt_q <= (state_q == ST_RSTX) ? cnt_q + 1'b1 : '0;
    end
  end

  always_comb begin
    req_o = '{fclk_en: 1'b1, hclk_en: 1'b1, sel_rc: 1'b0, reg_en: 1'b1};
    unique case (state_q)
      ST_SLEEP: req_o.hclk_en = cfg_i.sleep_dbg;
      ST_STOP: begin
        if (cfg_i.stop_dbg) req_o.sel_rc = 1'b1;
        else begin
          req_o.fclk_en = 1'b0;
          req_o.hclk_en = 1'b0;
        end
      end
      ST_STBY: begin
        if (cfg_i.stby_dbg) req_o.sel_rc = 1'b1;
        else begin
          req_o.fclk_en = 1'b0;
          req_o.hclk_en = 1'b0;
          req_o.reg_en  = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign sys_rst_req_o = (state_q == ST_RSTX);

  a_r3_no_spurious_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && !wfi_i && !wfe_i) |=> state_q == ST_RUN);

  a_r7_wake_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SLEEP || state_q == ST_STOP) && wake_i) |=> state_q == ST_RUN);

  a_r9_reset_only_from_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_req_o) |-> $past(state_q) == ST_STBY);

  a_r10_sysrst_to_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sys_rst_ni && state_q != ST_RSTX) |=> state_q == ST_RUN);
endmodule

// File: rtl/lp_clk_switch.sv
module lp_clk_switch
  import lp_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  lp_clk_req_t req_i,
  output logic        fclk_en_o,
  output logic        hclk_en_o,
  output logic        sel_o,
  output logic        reg_en_o
);
  logic sel_q, gate_q, match;

  assign match = (req_i.sel_rc == sel_q);

  // source moves only between two gated cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      gate_q <= 1'b0;
    end else if (!match) begin
      sel_q  <= req_i.sel_rc;
      gate_q <= 1'b1;
    end else begin
      gate_q <= 1'b0;
    end
  end

  assign fclk_en_o = req_i.fclk_en & match & ~gate_q;
  assign hclk_en_o = req_i.hclk_en & match & ~gate_q;
  assign sel_o     = sel_q;
  assign reg_en_o  = req_i.reg_en;

  a_r8_gated_before_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (!$past(fclk_en_o) && !$past(hclk_en_o)));

  a_r8_gated_after_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q != $past(sel_q)) |-> (!fclk_en_o && !hclk_en_o));
endmodule

// File: rtl/lp_clk_ctrl.sv
module lp_clk_ctrl
  import lp_pkg::*;
#(
  parameter int DW      = 32,
  parameter int RST_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sys_rst_ni,
  input  logic          wfi_i,
  input  logic          wfe_i,
  input  logic [1:0]    mode_i,
  input  logic          wake_i,
  input  logic          dbg_we_i,
  input  logic [DW-1:0] dbg_wdata_i,
  input  logic          sw_we_i,
  input  logic [DW-1:0] sw_wdata_i,
  output logic [DW-1:0] cfg_rdata_o,
  output logic          fclk_en_o,
  output logic          hclk_en_o,
  output logic          clk_sel_o,
  output logic          reg_en_o,
  output logic          sys_rst_req_o
);
  lp_cfg_t     cfg;
  lp_clk_req_t req;

  lp_dbg_cfg #(.DW(DW)) i_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dbg_we_i   (dbg_we_i),
    .dbg_wdata_i(dbg_wdata_i),
    .sw_we_i    (sw_we_i),
    .sw_wdata_i (sw_wdata_i),
    .cfg_o      (cfg),
    .rdata_o    (cfg_rdata_o)
  );

  lp_mode_fsm #(.RST_CYC(RST_CYC)) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sys_rst_ni   (sys_rst_ni),
    .wfi_i        (wfi_i),
    .wfe_i        (wfe_i),
    .mode_i       (mode_i),
    .wake_i       (wake_i),
    .cfg_i        (cfg),
    .req_o        (req),
    .sys_rst_req_o(sys_rst_req_o)
  );

  lp_clk_switch i_sw (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .fclk_en_o(fclk_en_o),
    .hclk_en_o(hclk_en_o),
    .sel_o    (clk_sel_o),
    .reg_en_o (reg_en_o)
  );
endmodule

// File: tb/test_lp_clk_ctrl.sv
module test_lp_clk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;

  logic clk_i = 1'b0, rst_ni = 1'b0, sys_rst_ni = 1'b1;
  logic wfi_i = 1'b0, wfe_i = 1'b0, wake_i = 1'b0;
  logic [1:0] mode_i = '0;
  logic dbg_we_i = 1'b0, sw_we_i = 1'b0;
  logic [DW-1:0] dbg_wdata_i = '0, sw_wdata_i = '0;
  logic [DW-1:0] cfg_rdata_o;
  logic fclk_en_o, hclk_en_o, clk_sel_o, reg_en_o, sys_rst_req_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  lp_clk_ctrl #(.DW(DW), .RST_CYC(4)) i_lp_clk_ctrl (.*);

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // order {fclk, hclk, sel, reg, rst}
  task automatic chk_out(input string tag, input logic [4:0] exp);
    chk(tag, {27'd0, fclk_en_o, hclk_en_o, clk_sel_o, reg_en_o, sys_rst_req_o}, {27'd0, exp});
  endtask

  task automatic wr(input bit dbg, input bit sw, input logic [DW-1:0] dv, input logic [DW-1:0] sv);
    dbg_we_i = dbg; sw_we_i = sw; dbg_wdata_i = dv; sw_wdata_i = sv;
    tick();
    dbg_we_i = 0; sw_we_i = 0;
  endtask

  task automatic enter(input logic [1:0] m, input bit use_wfe);
    mode_i = m; wfi_i = !use_wfe; wfe_i = use_wfe;
    tick();
    wfi_i = 0; wfe_i = 0;
  endtask

  task automatic wake();
    wake_i = 1; tick(); wake_i = 0;
  endtask

  task automatic t_reset();
    chk_out("R3 reset run outputs", 5'b11010);
    chk("R2 reset clears cfg", cfg_rdata_o, 0);
  endtask

  task automatic t_register();
    wr(0, 1, 0, 32'h5);
    chk("R1 sw write", cfg_rdata_o, 32'h5);
    wr(1, 0, 32'hFFFF_FFFA, 0);
    chk("R1 upper bits zero", cfg_rdata_o, 32'h2);
    wr(1, 1, 32'h4, 32'h3);
    chk("R1 debugger wins", cfg_rdata_o, 32'h4);
  endtask

  task automatic t_sysrst_reg();
    wr(0, 1, 0, 32'h7);
    sys_rst_ni = 0; tick();
    chk("R2 kept in sys reset", cfg_rdata_o, 32'h7);
    wr(1, 0, 32'h3, 0);
    chk("R2 writable in sys reset", cfg_rdata_o, 32'h3);
    sys_rst_ni = 1; tick();
    chk("R2 kept after sys reset", cfg_rdata_o, 32'h3);
  endtask

  task automatic t_no_entry();
    mode_i = 2'd1; wake_i = 1; tick(); tick();
    mode_i = 2'd2; tick();
    wake_i = 0;
    chk_out("R3 no entry without wfi/wfe", 5'b11010);
  endtask

  task automatic t_sleep(input bit dbg);
    wr(0, 1, 0, {31'd0, dbg});
    enter(2'd0, dbg);
    chk_out("R4 sleep outputs", {1'b1, dbg, 3'b010});
    wfi_i = 1; mode_i = 2'd1; tick(); wfi_i = 0;
    chk_out("R4 wfi ignored in sleep", {1'b1, dbg, 3'b010});
    wake();
    chk_out("R7 sleep wake run", 5'b11010);
  endtask

  task automatic t_stop(input bit dbg);
    wr(0, 1, 0, {30'd0, dbg, 1'b0});
    enter(2'd1, 1'b0);
    if (!dbg) begin
      chk_out("R5 stop no override", 5'b00010);
      wake();
      chk_out("R7 stop wake run", 5'b11010);
    end else begin
      chk_out("R8 stop gate before swap", 5'b00010);
      tick(); chk_out("R8 stop swap gated", 5'b00110);
      tick(); chk_out("R5 stop override rc", 5'b11110);
      wake();
      chk_out("R8 wake gate before swap", 5'b00110);
      tick(); chk_out("R8 wake swap gated", 5'b00010);
      tick(); chk_out("R7 stop wake run", 5'b11010);
    end
  endtask

  task automatic t_stby(input bit dbg, input logic [1:0] m);
    int pulses = 0;
    wr(1, 0, {29'd0, dbg, 2'b00}, 0);
    enter(m, 1'b1);
    if (!dbg) begin
      chk_out("R6 standby off", 5'b00000);
    end else begin
      chk_out("R8 standby gate before swap", 5'b00010);
      tick(); tick();
      chk_out("R6 standby override rc", 5'b11110);
    end
    wake();
    chk("R9 reset request first cycle", {31'd0, sys_rst_req_o}, 1);
    for (int i = 0; i < 8; i++) begin
      if (sys_rst_req_o) pulses++;
      tick();
    end
    chk("R9 reset pulse length", pulses, 4);
    chk_out("R9 run after standby exit", 5'b11010);
  endtask

  task automatic t_sysrst_fsm();
    wr(0, 1, 0, 0);
    enter(2'd1, 1'b0);
    chk_out("R10 in stop", 5'b00010);
    sys_rst_ni = 0; tick(); sys_rst_ni = 1;
    chk_out("R10 sys reset to run", 5'b11010);
    // pulse not shortened
    wr(0, 1, 0, 0);
    enter(2'd3, 1'b0);
    wake();
    sys_rst_ni = 0; tick(); tick(); tick(); sys_rst_ni = 1;
    chk("R10 pulse kept under sys reset", {31'd0, sys_rst_req_o}, 1);
    tick();
    chk("R10 pulse ends after 4", {31'd0, sys_rst_req_o}, 0);
  endtask

  task automatic t_por();
    wr(0, 1, 0, 32'h7);
    rst_ni = 0; tick();
    chk("R2 power-on reset clears", cfg_rdata_o, 0);
    rst_ni = 1; tick();
  endtask

  initial begin
    tick(); tick();
    rst_ni = 1;
    tick();
    t_reset();
    t_register();
    t_sysrst_reg();
    t_no_entry();
    t_sleep(0); t_sleep(1);
    t_stop(0);  t_stop(1);
    t_stby(0, 2'd2); t_stby(1, 2'd3);
    t_sysrst_fsm();
    t_por();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule